// File: doc/BRIEF.md
# Capture-Reload 16-bit Timer

This peripheral holds a 16-bit count that advances either once per clock or once per synchronized falling edge on an external count pin, gated by a run bit. A companion 16-bit capture/reload register either takes a snapshot of the count or supplies a preload value for it. A falling edge on an external trigger pin can cause the snapshot or the preload, and it raises an external flag. Which of the two happens depends on a select bit. In reload mode the count is also preloaded on every overflow. In capture mode an overflow wraps the count to zero.

Two clock-select bits put the block in baud mode. In that mode every overflow reloads the count, the overflow flag is held off, and a one-cycle tick is sent out as a serial bit clock. Software reaches the control byte and each byte of the count and of the capture/reload register through a small synchronous register bus. The interrupt request combines the two sticky flags.

Each external pin passes through a synchronizer into an edge state machine. The machine has three states: HIGH, FALL and LOW. HIGH moves to FALL when the synchronized sample reads 0. FALL lasts exactly one cycle and is the only state that reports an edge. From FALL the machine moves to LOW if the sample is still 0, or back to HIGH if it has returned to 1. LOW moves to HIGH when the sample reads 1. Reset enters HIGH.

Top module: `cr_timer16`

## Requirements
- R1: After reset the control byte, the count and the capture/reload register all read 0x00, and `irq` and `baud_tick` are low.
- R2: The register map is as follows. Address 0 is the control byte. Addresses 1 and 2 are the low and high bytes of the count. Addresses 3 and 4 are the low and high bytes of the capture/reload register. Unused addresses read 0. Control bits are: 7 overflow flag, 6 external flag, 5 receive-clock select, 4 transmit-clock select, 3 external enable, 2 run, 1 counter select, 0 capture select. A written value reads back unchanged while the run bit is 0.
- R3: With run=1 and counter select=0, the count advances by one on every clock, starting at the first edge after the control write. With run=0 the count holds.
- R4: With run=1 and counter select=1, the count advances by exactly one for each falling edge on `cnt_pin`.
- R5: When the count overflows from 0xFFFF outside baud mode, the overflow flag (bit 7) is set. The flag stays set until a control write clears it.
- R6: With capture select=0, the count is loaded from the capture/reload register on overflow.
- R7: With capture select=1 and external enable=1, a `trig_pin` falling edge copies the count into the capture/reload register and sets the external flag (bit 6).
- R8: With capture select=0 and external enable=1, a `trig_pin` falling edge loads the count from the capture/reload register and sets the external flag.
- R9: With external enable=0, a `trig_pin` falling edge is ignored: the flag, the count and the capture/reload register are all unchanged.
- R10: While bit 5 or bit 4 is set, every overflow reloads the count regardless of capture select, the overflow flag is never set, and `baud_tick` pulses high for one cycle per overflow.
- R11: `irq` is the overflow flag OR'd with the external flag, with the external flag masked while `dcen` is 1.
- R12: A bus write to a count byte takes precedence over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cnt_pin | input | 1 | External count input, falling edge counted |
| trig_pin | input | 1 | External capture/reload trigger, falling edge |
| dcen | input | 1 | Masks the external flag from `irq` when 1 |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-cycle pulse per overflow in baud mode |

## Verification
The assertions check the following on every cycle:
- the edge event never lasts more than one cycle;
- the count holds when no count, trigger or write event occurs;
- an overflow in reload or baud mode lands the preload value;
- a capture stores the prior count;
- the flags stay sticky, and the overflow flag stays off in baud mode;
- `baud_tick` appears only after a baud-mode cycle.

Only the bench scenarios can show the following:
- the exact count after a run start;
- one increment per external edge;
- the register layout and read-back;
- the number and spacing of baud ticks;
- write precedence over counting;
- the effect of `dcen` on `irq`.

// File: rtl/crt_pkg.sv
package crt_pkg;
    typedef enum logic [1:0] {
        EDG_HIGH = 2'd0,
        EDG_FALL = 2'd1,
        EDG_LOW  = 2'd2
    } edge_state_e;

    localparam int BIT_OVF    = 7;
    localparam int BIT_EXT    = 6;
    localparam int BIT_RXSEL  = 5;
    localparam int BIT_TXSEL  = 4;
    localparam int BIT_EXEN   = 3;
    localparam int BIT_RUN    = 2;
    localparam int BIT_CTSEL  = 1;
    localparam int BIT_CAPSEL = 0;
endpackage

// File: rtl/crt_edge_fsm.sv
module crt_edge_fsm
    import crt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sample;
    edge_state_e            state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
    assign sample = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDG_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_HIGH: if (!sample) state_d = EDG_FALL;
            EDG_FALL: state_d = sample ? EDG_HIGH : EDG_LOW;
            EDG_LOW:  if (sample)  state_d = EDG_HIGH;
            default:  state_d = EDG_HIGH;
        endcase
    end

    always_comb begin
        fall_o = (state_q == EDG_FALL);
    end

    // R4
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/crt_count_unit.sv
module crt_count_unit #(
    parameter int CNT_W = 16,
    localparam int BYTES = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_evt,
    input  logic             baud_mode,
    input  logic             cap_sel,
    input  logic             trig_evt,
    input  logic [BYTES-1:0] cnt_wr_mask,
    input  logic [BYTES-1:0] rc_wr_mask,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] rc_o,
    output logic             ovf_evt_o
);
    logic [CNT_W-1:0] count_q, count_d, rc_q, rc_d;
    logic             reload_now, capture_now;

    assign ovf_evt_o   = count_evt && (count_q == '1);
    assign reload_now  = (ovf_evt_o && (baud_mode || !cap_sel)) ||
                         (trig_evt && !cap_sel && !baud_mode);
    assign capture_now = trig_evt && cap_sel && !baud_mode;

    always_comb begin
        if (reload_now)     count_d = rc_q;
        else if (count_evt) count_d = count_q + CNT_W'(1);
        else                count_d = count_q;
        for (int b = 0; b < BYTES; b++)
            if (cnt_wr_mask[b]) count_d[b*8 +: 8] = wdata;
    end

    always_comb begin
        rc_d = capture_now ? count_q : rc_q;
        for (int b = 0; b < BYTES; b++)
            if (rc_wr_mask[b]) rc_d[b*8 +: 8] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            rc_q    <= '0;
        end else begin
            count_q <= count_d;
            rc_q    <= rc_d;
        end
    end

    assign count_o = count_q;
    assign rc_o    = rc_q;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_evt && !trig_evt && cnt_wr_mask == '0) |=> $stable(count_q));
    // R6
    ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt_o && (baud_mode || !cap_sel) && cnt_wr_mask == '0 && rc_wr_mask == '0)
        |=> count_q == $past(rc_q));
    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && cap_sel && !baud_mode && rc_wr_mask == '0)
        |=> rc_q == $past(count_q));
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import crt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              dcen,
    output logic              irq,
    output logic              baud_tick
);
    localparam int BYTES = CNT_W / 8;

    logic [7:0]       ctrl_q, ctrl_d;
    logic             ctrl_wr, baud_mode, count_evt, trig_evt;
    logic             cnt_fall, trig_fall, ovf_evt, tick_q;
    logic [BYTES-1:0] cnt_wr_mask, rc_wr_mask;
    logic [CNT_W-1:0] count_v, rc_v;

    crt_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin), .fall_o(cnt_fall));
    crt_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_trig_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(trig_pin), .fall_o(trig_fall));

    assign ctrl_wr   = bus_wr && (bus_addr == '0);
    assign baud_mode = ctrl_q[BIT_RXSEL] | ctrl_q[BIT_TXSEL];
    assign count_evt = ctrl_q[BIT_RUN] && (ctrl_q[BIT_CTSEL] ? cnt_fall : 1'b1);
    assign trig_evt  = trig_fall && ctrl_q[BIT_EXEN];

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign cnt_wr_mask[b] = bus_wr && (bus_addr == ADDR_W'(1 + b));
        assign rc_wr_mask[b]  = bus_wr && (bus_addr == ADDR_W'(1 + BYTES + b));
    end

    crt_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .count_evt(count_evt), .baud_mode(baud_mode),
        .cap_sel(ctrl_q[BIT_CAPSEL]), .trig_evt(trig_evt),
        .cnt_wr_mask(cnt_wr_mask), .rc_wr_mask(rc_wr_mask), .wdata(bus_wdata),
        .count_o(count_v), .rc_o(rc_v), .ovf_evt_o(ovf_evt));

    always_comb begin
        ctrl_d = ctrl_wr ? bus_wdata : ctrl_q;
        if (ovf_evt && !baud_mode) ctrl_d[BIT_OVF] = 1'b1;
        if (trig_evt)              ctrl_d[BIT_EXT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tick_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            tick_q <= ovf_evt && baud_mode;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = ctrl_q;
        for (int b = 0; b < BYTES; b++) begin
            if (bus_addr == ADDR_W'(1 + b))         bus_rdata = count_v[b*8 +: 8];
            if (bus_addr == ADDR_W'(1 + BYTES + b)) bus_rdata = rc_v[b*8 +: 8];
        end
    end

    assign irq       = ctrl_q[BIT_OVF] | (ctrl_q[BIT_EXT] & ~dcen);
    assign baud_tick = tick_q;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_mode && !ctrl_q[BIT_OVF] && !ctrl_wr) |=> !ctrl_q[BIT_OVF]);
    // R10
    tick_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(baud_mode));
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[BIT_OVF] && !ctrl_wr) |=> ctrl_q[BIT_OVF]);
    // R9
    ext_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[BIT_EXEN] && !ctrl_q[BIT_EXT] && !ctrl_wr) |=> !ctrl_q[BIT_EXT]);
endmodule

// File: tb/tb_cr_timer16.sv
module tb_cr_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_pin = 1'b1, trig_pin = 1'b1, dcen = 1'b0;
    logic       irq, baud_tick;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    cr_timer16 dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .dcen(dcen), .irq(irq), .baud_tick(baud_tick));

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic fall_on_trig();
        @(negedge clk); trig_pin = 1'b0;
        repeat (6) @(negedge clk);
        trig_pin = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check("R1 reset register", v, 0);
        end
        check("R1 reset irq", irq, 0);
        check("R1 reset baud_tick", baud_tick, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(3'd3, 8'hA5); wr(3'd4, 8'h5A); wr(3'd0, 8'h29);
        rd(3'd3, v); check("R2 rc low", v, 8'hA5);
        rd(3'd4, v); check("R2 rc high", v, 8'h5A);
        rd(3'd0, v); check("R2 ctrl readback", v, 8'h29);
        rd(3'd6, v); check("R2 unused address", v, 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_timer_run_stop();
        logic [15:0] a, b;
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        wr(3'd0, 8'h04);
        repeat (10) @(posedge clk);
        @(negedge clk);
        rd16(3'd1, a); check("R3 ten clocks counted", a, 10);
        wr(3'd0, 8'h00);
        rd16(3'd1, a);
        repeat (10) @(negedge clk);
        rd16(3'd1, b); check("R3 holds when stopped", b, a);
    endtask

    task automatic t_write_priority();
        logic [15:0] a;
        wr(3'd0, 8'h04);
        wr(3'd2, 8'h12);
        wr(3'd1, 8'h34);
        rd16(3'd1, a); check("R12 write over count", a, 16'h1234);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_reload_overflow();
        logic [15:0] a;
        logic [7:0]  v;
        wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        wr(3'd1, 8'hFD); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h04);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd16(3'd1, a); check("R6 before overflow", a, 16'hFFFF);
        @(negedge clk);
        rd16(3'd1, a); check("R6 reload on overflow", a, 16'h1234);
        rd(3'd0, v);   check("R5 overflow flag set", v, 8'h84);
        check("R11 irq from overflow", irq, 1);
        wr(3'd0, 8'h80);
        repeat (10) @(negedge clk);
        rd(3'd0, v);   check("R5 flag sticky", v, 8'h80);
        wr(3'd0, 8'h00);
        rd(3'd0, v);   check("R5 flag cleared", v, 0);
        check("R11 irq low", irq, 0);
    endtask

    task automatic t_counter_mode();
        logic [15:0] a;
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        wr(3'd0, 8'h06);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); cnt_pin = 1'b0;
            repeat (6) @(negedge clk);
            cnt_pin = 1'b1;
            repeat (6) @(negedge clk);
        end
        rd16(3'd1, a); check("R4 five edges counted", a, 5);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_capture();
        logic [15:0] a;
        logic [7:0]  v;
        wr(3'd1, 8'hCD); wr(3'd2, 8'hAB);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        wr(3'd0, 8'h09);
        fall_on_trig();
        rd16(3'd3, a); check("R7 captured count", a, 16'hABCD);
        rd(3'd0, v);   check("R7 external flag", v, 8'h49);
        check("R11 irq from external flag", irq, 1);
        dcen = 1'b1; #1;
        check("R11 dcen masks external flag", irq, 0);
        dcen = 1'b0;
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_reload();
        logic [15:0] a;
        logic [7:0]  v;
        wr(3'd3, 8'h55); wr(3'd4, 8'h55);
        wr(3'd1, 8'h01); wr(3'd2, 8'h00);
        wr(3'd0, 8'h08);
        fall_on_trig();
        rd16(3'd1, a); check("R8 trigger reload", a, 16'h5555);
        rd(3'd0, v);   check("R8 external flag", v, 8'h48);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_ignored();
        logic [15:0] a;
        logic [7:0]  v;
        wr(3'd1, 8'h02); wr(3'd2, 8'h00);
        wr(3'd0, 8'h01);
        fall_on_trig();
        rd(3'd0, v);   check("R9 no flag", v, 8'h01);
        rd16(3'd3, a); check("R9 rc unchanged", a, 16'h5555);
        wr(3'd0, 8'h00);
        fall_on_trig();
        rd16(3'd1, a); check("R9 count unchanged", a, 16'h0002);
        check("R9 irq low", irq, 0);
    endtask

    task automatic t_baud();
        logic [15:0] a;
        logic [7:0]  v;
        int pulses = 0;
        bit prev = 1'b0, twice = 1'b0;
        wr(3'd3, 8'hF0); wr(3'd4, 8'hFF);
        wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h24);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_tick) pulses++;
            if (baud_tick && prev) twice = 1'b1;
            prev = baud_tick;
        end
        check("R10 baud tick count", pulses, 3);
        check("R10 baud tick single cycle", twice, 0);
        rd(3'd0, v); check("R10 no overflow flag", v, 8'h24);
        check("R10 irq low", irq, 0);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h10); wr(3'd4, 8'h00);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h15);
        @(posedge clk); @(negedge clk);
        rd16(3'd1, a); check("R10 forced reload with capture select", a, 16'h0010);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_timer_run_stop();
        t_write_priority();
        t_reload_overflow();
        t_counter_mode();
        t_capture();
        t_trig_reload();
        t_trig_ignored();
        t_baud();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule